// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Test Registers

This block caches 32 page translations, each mapping a linear page number to a 20-bit physical page number together with dirty, user and writable attributes. The storage is split into 8 sets of 4 ways. A combinational lookup port takes a 32-bit linear address and returns, in the same cycle, a hit flag, the physical page and the attributes. Bits 14:12 of the address select the set, and bits 31:15 are compared against the stored tags.

Software has no fill path. It reaches the entries through two test registers. The tag register holds a linear page, a valid bit, the three attributes and a command bit. The physical register holds a physical page, a hit flag and a 2-bit way selector.

To install an entry, software loads the physical register first. It then writes the tag register with the command bit clear. To probe, it writes the tag register with the command bit set, and after one busy cycle it reads back the hit flag and the matching entry.

A small controller runs three states:
- ST_IDLE accepts register writes.
- ST_COMMIT writes the chosen way.
- ST_PROBE searches the set and updates the registers.

The transitions are:
- ST_IDLE to ST_COMMIT on a tag write with the command bit 0.
- ST_IDLE to ST_PROBE on a tag write with the command bit 1.
- ST_COMMIT to ST_IDLE and ST_PROBE to ST_IDLE, unconditionally after one cycle.

A flush input invalidates every entry in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, lk_hit is 0 for every address, tr_busy is 0, and both test registers read 0.
- R2: Tag register (tr_sel=0) layout: bits 31:12 linear page, bit 4 command, bit 3 valid, bit 2 dirty, bit 1 user, bit 0 writable. Bits 11:5 always read 0.
- R3: Physical register (tr_sel=1) layout: bits 31:12 physical page, bit 4 hit flag, bits 1:0 way selector. Other bits read 0. A write stores the page and way selector, and the hit flag keeps its value.
- R4: A tag write with command 0 makes tr_busy 1 for exactly one cycle. At the end of that cycle, way <way selector> of set <page bits 2:0> holds the page's upper 17 bits as tag, the valid bit, the attributes and the physical page.
- R5: lk_hit is 1 when a valid entry in set lk_addr[14:12] has tag lk_addr[31:15]. On a hit, lk_ppn and lk_attr ({dirty,user,writable}) come from that entry. On a miss, both read 0.
- R6: A tag write with command 1 makes tr_busy 1 for one cycle. On a hit, it then sets the hit flag, loads the entry's physical page and way into the physical register, and loads valid=1 and the entry's attributes into the tag register.
- R7: A probe that misses clears the hit flag and leaves the physical page, the way selector and the tag register unchanged.
- R8: Test-register writes presented while tr_busy is 1 are ignored.
- R9: A flush pulse invalidates all 32 entries by the next cycle. It takes priority over a commit in the same cycle.
- R10: The four ways of a set hold independent entries, and a commit replaces only the selected way. When two valid ways match, the lowest-numbered way is returned.
- R11: An entry committed with valid=0 never hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_addr | input | 32 | Lookup linear address |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page on hit, else 0 |
| lk_attr | output | 3 | {dirty,user,writable} on hit, else 0 |
| tr_wr_en | input | 1 | Test-register write strobe |
| tr_sel | input | 1 | Write target: 0 tag register, 1 physical register |
| tr_wdata | input | 32 | Test-register write data |
| tr_rd_sel | input | 1 | Readback select: 0 tag register, 1 physical register |
| tr_rdata | output | 32 | Selected register contents |
| tr_busy | output | 1 | Commit or probe in progress |

## Verification
Some properties hold on every cycle and are checked continuously:
- each busy period lasts one cycle;
- a commit lands in the addressed way;
- a flush leaves no valid entry;
- a missed probe keeps the physical fields;
- writes during a commit leave the registers untouched;
- a lookup miss drives zero data.

Other behaviour only shows through the bench's scenarios. This covers the readback layouts and the coexistence of four tags in one set. It also covers replacement of a single way, the lowest-way priority on duplicate tags, and entries committed invalid. The last scenario is a flush that collides with a commit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VA_W     = 32;
    parameter int PAGE_OFS = 12;
    parameter int NUM_SETS = 8;
    parameter int NUM_WAYS = 4;
    parameter int PPN_W    = 20;

    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int VPN_W  = VA_W - PAGE_OFS;
    localparam int TAG_W  = VPN_W - SET_W;

    // register field positions
    localparam int CMD_BIT = 4;
    localparam int VLD_BIT = 3;
    localparam int HIT_BIT = 4;

    localparam logic SEL_TAG  = 1'b0;
    localparam logic SEL_PHYS = 1'b1;

    typedef struct packed {
        logic dirty;
        logic user;
        logic wrt;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        attr_t            attr;
        logic [PPN_W-1:0] ppn;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_PROBE  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                wr_en,
    input  logic [SET_W-1:0]    wr_set,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic                wr_valid,
    input  entry_t              wr_entry,
    input  logic [SET_W-1:0]    rd_a_set,
    output logic [NUM_WAYS-1:0] rd_a_valid,
    output entry_t              rd_a_entry [NUM_WAYS],
    input  logic [SET_W-1:0]    rd_b_set,
    output logic [NUM_WAYS-1:0] rd_b_valid,
    output entry_t              rd_b_entry [NUM_WAYS]
);
    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    entry_t              ent_q   [NUM_SETS][NUM_WAYS];
    logic                any_valid;

    // valid bits: reset and flush clear all, flush beats commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
        end else if (flush) begin
            for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= wr_valid;
        end
    end

    // payload needs no reset; it is qualified by the valid bit
    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wr_set][wr_way] <= wr_entry;
    end

    assign rd_a_valid = valid_q[rd_a_set];
    assign rd_b_valid = valid_q[rd_b_set];

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_rd
        assign rd_a_entry[g] = ent_q[rd_a_set][g];
        assign rd_b_entry[g] = ent_q[rd_b_set][g];
    end

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_valid)
        else $error("flush left a valid entry");

    a_r4_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (valid_q[$past(wr_set)][$past(wr_way)] == $past(wr_valid)
                               && ent_q[$past(wr_set)][$past(wr_way)] == $past(wr_entry)))
        else $error("commit did not land in addressed way");
endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  logic [TAG_W-1:0]    tag,
    input  logic [NUM_WAYS-1:0] valid,
    input  entry_t              ent [NUM_WAYS],
    output logic                hit,
    output logic [WAY_W-1:0]    way,
    output entry_t              entry
);
    logic [NUM_WAYS-1:0] match;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign match[g] = valid[g] && (ent[g].tag == tag);
    end

    // lowest-numbered matching way wins
    always_comb begin
        hit   = 1'b0;
        way   = '0;
        entry = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit   = 1'b1;
                way   = WAY_W'(w);
                entry = ent[w];
            end
        end
    end
endmodule

// File: rtl/xlat_testreg_ctl.sv
module xlat_testreg_ctl
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tr_wr_en,
    input  logic             tr_sel,
    input  logic [VA_W-1:0]  tr_wdata,
    input  logic             tr_rd_sel,
    output logic [VA_W-1:0]  tr_rdata,
    output logic             tr_busy,
    input  logic             pr_hit,
    input  logic [WAY_W-1:0] pr_way,
    input  entry_t           pr_entry,
    output logic [SET_W-1:0] pr_set,
    output logic [TAG_W-1:0] pr_tag,
    output logic             wr_en,
    output logic [SET_W-1:0] wr_set,
    output logic [WAY_W-1:0] wr_way,
    output logic             wr_valid,
    output entry_t           wr_entry
);
    ctl_state_e state_q, state_d;

    logic [VPN_W-1:0] page_q;
    logic             cmd_q;
    logic             v_q;
    attr_t            attr_q;
    logic [PPN_W-1:0] ppn_q;
    logic             pl_q;
    logic [WAY_W-1:0] rep_q;
    logic             accept;
    logic             unused_bits;

    assign unused_bits = ^{tr_wdata[PAGE_OFS-1:CMD_BIT+1], pr_entry.tag};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tr_wr_en && tr_sel == SEL_TAG)
                    state_d = tr_wdata[CMD_BIT] ? ST_PROBE : ST_COMMIT;
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_PROBE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state-derived outputs
    always_comb begin
        tr_busy = (state_q != ST_IDLE);
        wr_en   = (state_q == ST_COMMIT);
        accept  = (state_q == ST_IDLE) && tr_wr_en;
    end

    assign wr_set   = page_q[SET_W-1:0];
    assign wr_way   = rep_q;
    assign wr_valid = v_q;
    assign wr_entry = '{tag: page_q[VPN_W-1:SET_W], attr: attr_q, ppn: ppn_q};
    assign pr_set   = page_q[SET_W-1:0];
    assign pr_tag   = page_q[VPN_W-1:SET_W];

    // test registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            cmd_q  <= 1'b0;
            v_q    <= 1'b0;
            attr_q <= '0;
            ppn_q  <= '0;
            pl_q   <= 1'b0;
            rep_q  <= '0;
        end else begin
            if (accept && tr_sel == SEL_TAG) begin
                page_q <= tr_wdata[VA_W-1:PAGE_OFS];
                cmd_q  <= tr_wdata[CMD_BIT];
                v_q    <= tr_wdata[VLD_BIT];
                attr_q <= attr_t'(tr_wdata[ATTR_W-1:0]);
            end else if (accept) begin
                ppn_q  <= tr_wdata[PAGE_OFS +: PPN_W];
                rep_q  <= tr_wdata[WAY_W-1:0];
            end
            if (state_q == ST_PROBE) begin
                if (pr_hit) begin
                    pl_q   <= 1'b1;
                    ppn_q  <= pr_entry.ppn;
                    rep_q  <= pr_way;
                    v_q    <= 1'b1;
                    attr_q <= pr_entry.attr;
                end else begin
                    pl_q   <= 1'b0;
                end
            end
        end
    end

    // readback
    always_comb begin
        tr_rdata = '0;
        if (tr_rd_sel == SEL_TAG) begin
            tr_rdata[VA_W-1:PAGE_OFS] = page_q;
            tr_rdata[CMD_BIT]         = cmd_q;
            tr_rdata[VLD_BIT]         = v_q;
            tr_rdata[ATTR_W-1:0]      = attr_q;
        end else begin
            tr_rdata[PAGE_OFS +: PPN_W] = ppn_q;
            tr_rdata[HIT_BIT]           = pl_q;
            tr_rdata[WAY_W-1:0]         = rep_q;
        end
    end

    a_r4_one_cycle_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tr_busy |=> !tr_busy)
        else $error("busy lasted more than one cycle");

    a_r6_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE && pr_hit) |=> (pl_q && v_q))
        else $error("probe hit did not set hit flag");

    a_r7_miss_keeps_phys: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE && !pr_hit) |=> (!pl_q && $stable(ppn_q) && $stable(rep_q)))
        else $error("probe miss altered physical register");

    a_r8_commit_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> ($stable(page_q) && $stable(ppn_q) && $stable(rep_q)))
        else $error("register changed during commit");

    a_r3_flag_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tr_wr_en && tr_sel == SEL_PHYS) |=> $stable(pl_q))
        else $error("hit flag changed by a register write");
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [VA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              tr_wr_en,
    input  logic              tr_sel,
    input  logic [VA_W-1:0]   tr_wdata,
    input  logic              tr_rd_sel,
    output logic [VA_W-1:0]   tr_rdata,
    output logic              tr_busy
);
    logic [NUM_WAYS-1:0] a_valid, b_valid;
    entry_t              a_ent [NUM_WAYS];
    entry_t              b_ent [NUM_WAYS];

    logic             wr_en, wr_valid;
    logic [SET_W-1:0] wr_set, pr_set;
    logic [WAY_W-1:0] wr_way, pr_way, lk_way;
    entry_t           wr_entry, pr_entry, lk_entry;
    logic [TAG_W-1:0] pr_tag;
    logic             pr_hit, lk_match;
    logic             unused_lk;

    assign unused_lk = ^{lk_addr[PAGE_OFS-1:0], lk_way, lk_entry.tag};

    xlat_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .wr_en      (wr_en),
        .wr_set     (wr_set),
        .wr_way     (wr_way),
        .wr_valid   (wr_valid),
        .wr_entry   (wr_entry),
        .rd_a_set   (lk_addr[PAGE_OFS +: SET_W]),
        .rd_a_valid (a_valid),
        .rd_a_entry (a_ent),
        .rd_b_set   (pr_set),
        .rd_b_valid (b_valid),
        .rd_b_entry (b_ent)
    );

    xlat_match u_lk_match (
        .tag   (lk_addr[VA_W-1:PAGE_OFS+SET_W]),
        .valid (a_valid),
        .ent   (a_ent),
        .hit   (lk_match),
        .way   (lk_way),
        .entry (lk_entry)
    );

    xlat_match u_pr_match (
        .tag   (pr_tag),
        .valid (b_valid),
        .ent   (b_ent),
        .hit   (pr_hit),
        .way   (pr_way),
        .entry (pr_entry)
    );

    xlat_testreg_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tr_wr_en  (tr_wr_en),
        .tr_sel    (tr_sel),
        .tr_wdata  (tr_wdata),
        .tr_rd_sel (tr_rd_sel),
        .tr_rdata  (tr_rdata),
        .tr_busy   (tr_busy),
        .pr_hit    (pr_hit),
        .pr_way    (pr_way),
        .pr_entry  (pr_entry),
        .pr_set    (pr_set),
        .pr_tag    (pr_tag),
        .wr_en     (wr_en),
        .wr_set    (wr_set),
        .wr_way    (wr_way),
        .wr_valid  (wr_valid),
        .wr_entry  (wr_entry)
    );

    assign lk_hit  = lk_match;
    assign lk_ppn  = lk_match ? lk_entry.ppn  : '0;
    assign lk_attr = lk_match ? lk_entry.attr : '0;

    a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && lk_attr == '0))
        else $error("lookup miss drove data");
endmodule

// File: tb/xlat_buffer_tb.sv
`timescale 1ns/1ps
module xlat_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [2:0]  lk_attr;
    logic        tr_wr_en = 1'b0;
    logic        tr_sel = 1'b0;
    logic [31:0] tr_wdata = '0;
    logic        tr_rd_sel = 1'b0;
    logic [31:0] tr_rdata;
    logic        tr_busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xlat_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
        .tr_wr_en(tr_wr_en), .tr_sel(tr_sel), .tr_wdata(tr_wdata),
        .tr_rd_sel(tr_rd_sel), .tr_rdata(tr_rdata), .tr_busy(tr_busy)
    );

    // {page[19:0], ppn[19:0], way[1:0], {V,D,U,W}}
    localparam logic [45:0] VEC [0:5] = '{
        {20'h12345, 20'hABCDE, 2'd0, 4'b1101},
        {20'h7777D, 20'h00111, 2'd1, 4'b1010},
        {20'h0000D, 20'h22222, 2'd2, 4'b1111},
        {20'hFFFF5, 20'h33333, 2'd3, 4'b1000},
        {20'h00000, 20'h44444, 2'd0, 4'b1001},
        {20'h80007, 20'hFFFFF, 2'd3, 4'b0111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tr_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        tr_wr_en = 1'b1;
        tr_sel   = sel;
        tr_wdata = data;
        @(negedge clk);
        tr_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (tr_busy) @(negedge clk);
    endtask

    task automatic commit(input logic [19:0] page, input logic [19:0] ppn,
                          input logic [1:0] way, input logic [3:0] vduw);
        tr_write(1'b1, {ppn, 10'b0, way});
        tr_write(1'b0, {page, 7'b0, 1'b0, vduw});
        wait_idle();
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] val);
        tr_rd_sel = sel;
        #1;
        val = tr_rdata;
    endtask

    task automatic check_lookup(input string req, input logic [19:0] page, input logic exp_hit,
                                input logic [19:0] exp_ppn, input logic [2:0] exp_attr);
        lk_addr = {page, 12'hABC};
        #1;
        chk(req, {8'b0, lk_attr, lk_hit, lk_ppn}, {8'b0, exp_attr, exp_hit, exp_ppn});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'b0, tr_busy}, 32'h0);
        read_reg(1'b0, rv); chk("R1 tag reg", rv, 32'h0);
        read_reg(1'b1, rv); chk("R1 phys reg", rv, 32'h0);
        check_lookup("R1 lookup", 20'h12345, 1'b0, 20'h0, 3'b0);

        // R2 tag register layout (command bit set: a probe on an empty store)
        tr_write(1'b0, 32'h12345FFF);
        wait_idle();
        read_reg(1'b0, rv); chk("R2 tag readback", rv, 32'h1234501F);

        // R3 physical register layout, hit flag not writable
        tr_write(1'b1, 32'hABCDE7FF);
        read_reg(1'b1, rv); chk("R3 phys readback", rv, 32'hABCDE003);

        // R4 R5 R10 R11 table: commit then look up each entry
        for (int i = 0; i < 6; i++) begin
            logic [45:0] v;
            v = VEC[i];
            tr_write(1'b1, {v[25:6], 10'b0, v[5:4]});
            tr_write(1'b0, {v[45:26], 7'b0, 1'b0, v[3:0]});
            chk("R4 busy one cycle", {31'b0, tr_busy}, 32'h1);
            @(negedge clk);
            chk("R4 busy drops", {31'b0, tr_busy}, 32'h0);
            check_lookup("R5 R11 table lookup", v[45:26], v[3], v[3] ? v[25:6] : 20'h0,
                         v[3] ? v[2:0] : 3'b0);
        end
        for (int i = 0; i < 6; i++) begin
            logic [45:0] v;
            v = VEC[i];
            check_lookup("R10 ways coexist", v[45:26], v[3], v[3] ? v[25:6] : 20'h0,
                         v[3] ? v[2:0] : 3'b0);
        end

        // R6 probe hit on way 2 of set 5
        tr_write(1'b0, 32'h0000D010);
        wait_idle();
        read_reg(1'b1, rv); chk("R6 probe phys", rv, 32'h22222012);
        read_reg(1'b0, rv); chk("R6 probe tag", rv, 32'h0000D01F);

        // R7 probe miss keeps physical fields and tag attributes
        tr_write(1'b1, 32'h0BEEF001);
        tr_write(1'b0, 32'h55555016);
        wait_idle();
        read_reg(1'b1, rv); chk("R7 miss phys", rv, 32'h0BEEF001);
        read_reg(1'b0, rv); chk("R7 miss tag", rv, 32'h55555016);

        // R8 write during busy cycle ignored
        tr_write(1'b1, 32'h01234000);
        tr_write(1'b0, 32'h55555010);
        tr_wr_en = 1'b1; tr_sel = 1'b1; tr_wdata = 32'h99999003;
        @(negedge clk);
        tr_wr_en = 1'b0;
        read_reg(1'b1, rv); chk("R8 busy write ignored", rv, 32'h01234000);

        // R10 duplicate tag: lowest way wins; way 3 replaced
        commit(20'h12345, 20'h5A5A5, 2'd3, 4'b1000);
        check_lookup("R10 lowest way wins", 20'h12345, 1'b1, 20'hABCDE, 3'b101);
        check_lookup("R10 replaced way", 20'hFFFF5, 1'b0, 20'h0, 3'b0);
        // R11 invalidating way 0 exposes way 3
        commit(20'h12345, 20'h00000, 2'd0, 4'b0000);
        check_lookup("R11 invalid commit", 20'h12345, 1'b1, 20'h5A5A5, 3'b000);

        // R9 flush
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        check_lookup("R9 flush set5", 20'h0000D, 1'b0, 20'h0, 3'b0);
        check_lookup("R9 flush set0", 20'h00000, 1'b0, 20'h0, 3'b0);
        check_lookup("R9 flush dup", 20'h12345, 1'b0, 20'h0, 3'b0);
        // R9 flush beats a commit in the same cycle
        tr_write(1'b1, 32'h44444000);
        tr_write(1'b0, 32'h00000009);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check_lookup("R9 flush over commit", 20'h00000, 1'b0, 20'h0, 3'b0);
        commit(20'h00000, 20'h44444, 2'd0, 4'b1001);
        check_lookup("R4 commit after flush", 20'h00000, 1'b1, 20'h44444, 3'b001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule